// File: doc/BRIEF.md
# Reset-Forced Jump Fetch Sequencer

This block is the fetch and sequencing front end of a small 8-bit processor core. It does not clear the program counter when the core leaves reset. Instead, it runs an ordinary long-jump instruction. While reset is held, the instruction register is filled with the long-jump opcode 0x02 on every cycle.

After reset is released, the sequencer decodes that opcode the same way it decodes an opcode fetched from the bus. It then walks through the two address-operand cycles. In those two cycles a short counter replaces the bus data with zero bytes, so the jump target is 0x0000. Normal opcode fetch then starts at that address.

Outside of reset, the sequencer treats a bus byte as an opcode only in the fetch state. A long jump fetched from memory takes its high address byte and then its low address byte from the bus. The program counter advances after each of those byte reads.

Top module: `bootjump_fetch`

## Requirements
- R1: On every clock edge with `rst` high, the block sets `ir_q` to 0x02 and `seq_state` to 0. From the cycle after that edge, `rd_strobe` is low. State codes are 0 = opcode fetch, 1 = high address byte, 2 = low address byte.
- R2: Reset is synchronous and overrides everything, including the middle of an operand sequence. Reset does not change `pc`; it keeps its value.
- R3: In the first cycle after reset is released, `rd_strobe` is low. The block decodes the opcode already held in `ir_q`, and `seq_state` moves to 1.
- R4: In the two operand cycles that follow a reset-forced jump, `rd_strobe` is low, the bus value has no effect, and `pc` does not advance.
- R5: After the second substituted operand, `pc` is 0x0000, `seq_state` is 0, and `rd_strobe` is high.
- R6: In a normal fetch (state 0, `rd_strobe` high), the bus byte is loaded into `ir_q` and `pc` advances by one. An opcode other than 0x02 keeps the state at 0.
- R7: A fetched opcode 0x02 moves the state to 1. The block then reads the high byte and the low byte from the bus with `rd_strobe` high. `pc` advances after the high byte. After the low byte, `pc` is loaded with {high, low} and the state returns to 0.
- R8: Bus bytes read in states 1 and 2 are never taken as opcodes. `ir_q` does not change in those states, even when the byte is 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | System data bus read value |
| ir_q | output | 8 | Instruction register |
| pc | output | 16 | Program counter, also the read address |
| rd_strobe | output | 1 | High when the current cycle consumes the bus byte |
| seq_state | output | 2 | Sequencer state (0 fetch, 1 high byte, 2 low byte) |

## Verification
An error in the state register or in the substitution counter appears at the ports within one or two cycles. It shows up as a read strobe in a cycle that should ignore the bus, or as a missing strobe in a cycle that should read it. It also shows up as a state code that does not follow the 0, 1, 2 order.

If the bus leaks into a substituted operand cycle, the first fetch after reset does not start at 0x0000. If an operand byte is mistaken for an opcode, the instruction register changes in a state where it must hold. From then on the fetched stream no longer matches the bench's byte-level model of memory.

// File: rtl/bjf_pkg.sv
package bjf_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_OPHI  = 2'd1,
    ST_OPLO  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/bjf_decode.sv
// Opcode source select and long-jump decode: one path for every opcode,
// whether it was forced by reset or read from the bus.
module bjf_decode #(
  parameter int                 DATA_W  = 8,
  parameter logic [DATA_W-1:0]  LJMP_OP = 8'h02
) (
  input  logic              boot_pend,
  input  logic [DATA_W-1:0] ir_q,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] op_src,
  output logic              is_ljmp
);
  always_comb begin
    op_src  = boot_pend ? ir_q : bus_data;
    is_ljmp = (op_src == LJMP_OP);
  end
endmodule

// File: rtl/bjf_zerosub.sv
// Operand zero-substitution counter: armed by a reset-origin jump,
// counts down once per operand cycle, masks the bus while nonzero.
module bjf_zerosub #(
  parameter int DATA_W     = 8,
  parameter int SUB_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              adv,
  input  logic [DATA_W-1:0] bus_data,
  output logic              sub_active,
  output logic [DATA_W-1:0] opnd_data
);
  localparam int CNT_W = $clog2(SUB_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= CNT_W'(SUB_CYCLES);
    end else if (adv && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    sub_active = (cnt_q != '0);
    opnd_data  = sub_active ? '0 : bus_data;
  end

  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SUB_CYCLES)) else $error("substitution count out of range"); // R4
endmodule

// File: rtl/bjf_pcunit.sv
// Program counter and high-operand holding register. No reset clear:
// the start address arrives through the jump load.
module bjf_pcunit #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inc,
  input  logic                cap_hi,
  input  logic                load,
  input  logic [DATA_W-1:0]   opnd,
  output logic [2*DATA_W-1:0] pc
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] hi_q;
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (cap_hi) begin
        hi_q <= opnd;
      end
      if (load) begin
        pc_q <= {hi_q, opnd};
      end else if (inc) begin
        pc_q <= pc_q + ADDR_W'(1);
      end
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/bootjump_fetch.sv
module bootjump_fetch
  import bjf_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] LJMP_OP    = 8'h02,
  parameter int                SUB_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   bus_data,
  output logic [DATA_W-1:0]   ir_q,
  output logic [2*DATA_W-1:0] pc,
  output logic                rd_strobe,
  output logic [1:0]          seq_state
);
  localparam int ADDR_W = 2 * DATA_W;

  seq_st_e           st_q;
  logic              boot_pend_q;
  logic [DATA_W-1:0] ir_r;

  logic [DATA_W-1:0] op_src;
  logic              is_ljmp;
  logic              sub_active;
  logic [DATA_W-1:0] opnd_data;
  logic              arm_sub, adv_sub;
  logic              pc_inc, pc_cap_hi, pc_load;

  bjf_decode #(.DATA_W(DATA_W), .LJMP_OP(LJMP_OP)) u_decode (
    .boot_pend (boot_pend_q),
    .ir_q      (ir_r),
    .bus_data  (bus_data),
    .op_src    (op_src),
    .is_ljmp   (is_ljmp)
  );

  bjf_zerosub #(.DATA_W(DATA_W), .SUB_CYCLES(SUB_CYCLES)) u_zerosub (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm_sub),
    .adv        (adv_sub),
    .bus_data   (bus_data),
    .sub_active (sub_active),
    .opnd_data  (opnd_data)
  );

  bjf_pcunit #(.DATA_W(DATA_W)) u_pcunit (
    .clk    (clk),
    .rst    (rst),
    .inc    (pc_inc),
    .cap_hi (pc_cap_hi),
    .load   (pc_load),
    .opnd   (opnd_data),
    .pc     (pc)
  );

  // Strobe is a decode of registered state only.
  always_comb begin
    if (st_q == ST_FETCH) rd_strobe = !boot_pend_q;
    else                  rd_strobe = !sub_active;
  end

  always_comb begin
    arm_sub   = !rst && (st_q == ST_FETCH) && boot_pend_q && is_ljmp;
    adv_sub   = !rst && (st_q != ST_FETCH);
    pc_inc    = !rst && (((st_q == ST_FETCH) && !boot_pend_q) ||
                         ((st_q == ST_OPHI) && !sub_active));
    pc_cap_hi = !rst && (st_q == ST_OPHI);
    pc_load   = !rst && (st_q == ST_OPLO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_FETCH;
      boot_pend_q <= 1'b1;
      ir_r        <= LJMP_OP;
    end else begin
      unique case (st_q)
        ST_FETCH: begin
          if (!boot_pend_q) ir_r <= bus_data;
          boot_pend_q <= 1'b0;
          st_q        <= is_ljmp ? ST_OPHI : ST_FETCH;
        end
        ST_OPHI: st_q <= ST_OPLO;
        ST_OPLO: st_q <= ST_FETCH;
        default: st_q <= ST_FETCH;
      endcase
    end
  end

  assign ir_q      = ir_r;
  assign seq_state = st_q;

  AST_RST_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_q == LJMP_OP && seq_state == 2'd0 && !rd_strobe)) else $error("reset entry"); // R1
  AST_BOOT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OPLO && sub_active) |=> (pc == '0 && seq_state == 2'd0 && rd_strobe)) else $error("boot target"); // R5
  AST_OPND_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_FETCH) |=> $stable(ir_q)) else $error("ir changed in operand"); // R8
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FETCH && rd_strobe) |=> (pc == $past(pc) + ADDR_W'(1))) else $error("fetch step"); // R6
  AST_LJMP_ENTER: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FETCH && rd_strobe && bus_data == LJMP_OP) |=> (seq_state == 2'd1)) else $error("ljmp entry"); // R7
endmodule

// File: tb/bootjump_fetch_bench.sv
module bootjump_fetch_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_data = 8'h00;
  logic [7:0]  ir_q;
  logic [15:0] pc;
  logic        rd_strobe;
  logic [1:0]  seq_state;

  bootjump_fetch u_bootjump_fetch (
    .clk(clk), .rst(rst), .bus_data(bus_data),
    .ir_q(ir_q), .pc(pc), .rd_strobe(rd_strobe), .seq_state(seq_state)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [7:0] mem [256];
  logic       force_en = 1'b1;
  logic [7:0] force_val = 8'hFF;

  // bench model state
  int          m_st = 0;
  logic        m_boot = 1'b0;
  int          m_sub = 0;
  logic [7:0]  m_ir = 8'h00;
  logic [15:0] m_pc = 16'h0000;
  logic [7:0]  m_hi = 8'h00;
  logic        pc_known = 1'b0;
  logic        started = 1'b0;
  logic        mid_rst = 1'b0;
  logic        after_boot = 1'b0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected under 100000", cyc);
      summary();
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic fill_mem(int p);
    for (int a = 0; a < 256; a++) mem[a] = 8'((a * (37 + 8 * p) + 11 + p) & 255);
    mem[3] = 8'h02;        // long jump at address 3 (R7)
    mem[4] = 8'h02;        // high operand equal to the opcode (R8)
    mem[5] = 8'(8'h10 + p);
  endtask

  // One clock: drive bus, clock, then update the model and compare.
  task automatic tick();
    string       tg, tg_ir;
    logic [7:0]  b;
    bus_data = force_en ? force_val : mem[pc[7:0]];
    b = bus_data;
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      tg = mid_rst ? "R2" : "R1"; tg_ir = tg;
      m_st = 0; m_boot = 1'b1; m_ir = 8'h02; m_sub = 0;
      started = 1'b1; after_boot = 1'b0;
    end else begin
      case (m_st)
        0: begin
          if (m_boot) begin
            tg = "R3"; tg_ir = "R3";
            m_boot = 1'b0;
            if (m_ir == 8'h02) begin m_st = 1; m_sub = 2; end
          end else begin
            tg = after_boot ? "R5" : "R6"; tg_ir = tg;
            m_ir = b; m_pc = m_pc + 16'd1;
            if (b == 8'h02) m_st = 1;
          end
          after_boot = 1'b0;
        end
        1: begin
          tg = (m_sub != 0) ? "R4" : "R7"; tg_ir = "R8";
          if (m_sub != 0) begin m_hi = 8'h00; m_sub = m_sub - 1; end
          else begin m_hi = b; m_pc = m_pc + 16'd1; end
          m_st = 2;
        end
        default: begin
          tg = (m_sub != 0) ? "R4" : "R7"; tg_ir = "R8";
          if (m_sub != 0) begin
            m_pc = 16'h0000; m_sub = m_sub - 1;
            pc_known = 1'b1; after_boot = 1'b1;
          end else begin
            m_pc = {m_hi, b};
          end
          m_st = 0;
        end
      endcase
    end
    if (started) begin
      check(tg_ir, "ir", {8'h00, ir_q}, {8'h00, m_ir});
      check(tg, "state", {14'd0, seq_state}, 16'(m_st));
      check(tg, "rd_strobe", {15'd0, rd_strobe},
            {15'd0, (m_st == 0) ? !m_boot : (m_sub == 0)});
      if (pc_known) check(tg, "pc", pc, m_pc);
    end
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      fill_mem(p);
      // reset with noisy bus (R1)
      rst = 1'b1; force_en = 1'b1;
      for (int k = 0; k < 3; k++) begin force_val = 8'(8'hF0 + k + p); tick(); end
      // release: decode cycle and two substituted operands see junk (R3, R4)
      rst = 1'b0;
      for (int k = 0; k < 3; k++) begin force_val = 8'(8'hA5 ^ (k * 17 + p)); tick(); end
      // free-running fetch from memory (R5..R8)
      force_en = 1'b0;
      for (int k = 0; k < 600; k++) tick();
      // reset in the middle of an operand sequence (R2)
      for (int k = 0; k < 2000 && !(m_st == 1 && m_sub == 0); k++) tick();
      mid_rst = 1'b1; rst = 1'b1;
      tick();
      mid_rst = 1'b0;
    end
    rst = 1'b0; force_en = 1'b1; force_val = 8'h77;
    for (int k = 0; k < 3; k++) tick();
    force_en = 1'b0;
    for (int k = 0; k < 50; k++) tick();
    summary();
  end
endmodule